// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache Front End

This block is a small direct-mapped data cache placed between a processor-side word port and a plain memory port. The processor presents an address and raises a request strobe; a four-bit byte-enable field decides between a load (all enables zero) and a store (any enable set). Ready comes back one cycle after the request. On a load, the returned word is valid in that same cycle. A requester that keeps its strobe high and moves to a new address every cycle gets one word per clock for as long as it hits.

A load miss fetches the whole line from memory, one word per transfer, lowest offset first. The line is then marked valid under its new tag and the load is answered from it. Every store goes straight through to memory. If the line is resident, the cached copy is also updated under the byte enables; a store miss does not allocate. The processor is held, with ready low, until the memory transfer ends. Each memory channel has its own valid/ready pair, and only one memory transfer is in flight at a time.

Geometry comes from parameters: address width, data width, words per line (a power of two, at least two) and number of lines. The default is 32-bit words, four-word lines and sixteen lines.

Top module: `dcache_frontend`

## Requirements
- R1: A request whose byte enables are all zero is a load and causes no memory write; a request with any enable set is a store.
- R2: A load that hits raises ready in the cycle after the request, with the addressed word on the read-data output in that same cycle.
- R3: With the request strobe held high and a new address each cycle, hitting loads complete on consecutive cycles with no idle cycle between them.
- R4: If the strobe is low in the cycle where ready is high, no further request is taken: ready and both memory channels stay low afterwards.
- R5: A load miss reads the line over the memory read channel at word-aligned addresses (tag, index, offset, two zero bits), offsets ascending from 0. A word is taken in the cycle its read-ready is high. Ready reaches the processor six cycles after the request when memory answers at once.
- R6: A store is sent on the memory write channel with its word address, data and byte enables. Ready reaches the processor in the cycle the write channel's ready is high, which is two cycles after the request when memory answers at once.
- R7: A store that hits updates only the enabled bytes of the cached word; a store that misses leaves the cache unchanged, so a later load of that line misses.
- R8: Reset marks every line invalid and drops ready and both memory valids, so the first access after reset to any address misses.
- R9: While a memory valid is high and its ready is low, the address (and, for writes, data and enables) stays unchanged; the read and write channels are never valid together.
- R10: A load issued in the cycle a store to the same word completes returns the bytes that store wrote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request strobe |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_wstrb | input | DATA_W/8 | Byte enables; zero means load |
| cpu_rdata | output | DATA_W | Load data, valid with ready |
| cpu_ready | output | 1 | Request completed |
| mem_r_valid | output | 1 | Memory read request |
| mem_r_addr | output | ADDR_W | Memory read word address |
| mem_r_data | input | DATA_W | Memory read data, taken with read-ready |
| mem_r_ready | input | 1 | Memory read completes |
| mem_w_valid | output | 1 | Memory write request |
| mem_w_addr | output | ADDR_W | Memory write word address |
| mem_w_data | output | DATA_W | Memory write data |
| mem_w_strb | output | DATA_W/8 | Memory write byte enables |
| mem_w_ready | input | 1 | Memory write completes |

## Verification
The lookup path gets four kinds of traffic. Isolated loads and stores, mixing hits, misses and two tags on one index, separate the hit, refill and store timing by how many cycles ready takes. A held-strobe stream over a resident line shows that no bubble appears between hits. A load placed right behind a store to the same word, and a store miss followed by a load, show whether byte merging and the no-allocate rule are right. A slow memory, together with a reset in the middle of the run, checks that transfers are held stable and that lines are invalidated.

// File: rtl/dc_pkg.sv
// Shared types of the data cache front end.
package dc_pkg;
    // Controller state: look up the staged request, refill a line, or forward a store.
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_REFILL = 2'd1,
        ST_WRITE  = 2'd2
    } dc_state_t;
endpackage

// File: rtl/dc_tag_store.sv
// Per-line valid bit and tag, held in flops.
// Compares combinationally against the staged request; one write port sets a line valid.
// Assumes a line is only ever written as a whole by a refill.
module dc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic             line_valid [LINES];
    logic [TAG_W-1:0] line_tag   [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Clear the valid bit on reset; load tag and valid when this line is refilled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_valid[i] <= 1'b0;
                line_tag[i]   <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                line_valid[i] <= 1'b1;
                line_tag[i]   <= wr_tag;
            end
        end
    end

    // Hit when the indexed line is valid and its tag matches.
    always_comb hit = line_valid[rd_idx] && (line_tag[rd_idx] == rd_tag);
endmodule

// File: rtl/dc_data_store.sv
// Word storage for all lines: one combinational read port, one byte-enabled write port.
// Writes take effect at the clock edge, so a read one cycle later sees the new bytes.
// Assumes data contents need no reset (valid bits gate their use).
module dc_data_store #(
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int LINE_WORDS = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WOFF_W = $clog2(LINE_WORDS),
    localparam int BYTES  = DATA_W / 8,
    localparam int DEPTH  = LINES * LINE_WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WOFF_W-1:0] rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WOFF_W-1:0] wr_off,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] words [DEPTH];

    // Write the enabled byte lanes of the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[b]) words[{wr_idx, wr_off}][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    // Read the addressed word.
    always_comb rd_data = words[{rd_idx, rd_off}];
endmodule

// File: rtl/dc_ctrl.sv
// Sequencer of the cache: decides hit completion, runs line refills and
// forwards stores to memory, one memory transfer at a time.
// Assumes the staged request stays unchanged until ready is given.
module dc_ctrl #(
    parameter int LINE_WORDS = 4,
    localparam int WOFF_W = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              hit,
    input  logic              mem_r_ready,
    input  logic              mem_w_ready,
    output logic              cpu_ready,
    output logic              mem_r_valid,
    output logic              mem_w_valid,
    output logic [WOFF_W-1:0] refill_off,
    output logic              refill_we,
    output logic              tag_we,
    output logic              store_we
);
    import dc_pkg::*;

    localparam logic [WOFF_W-1:0] LAST_OFF = WOFF_W'(LINE_WORDS - 1);

    dc_state_t state_q, state_d;
    logic [WOFF_W-1:0] off_q;

    // Next-state and per-cycle strobes.
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        refill_we = 1'b0;
        tag_we    = 1'b0;
        store_we  = 1'b0;
        case (state_q)
            ST_LOOKUP: begin
                if (req_valid) begin
                    if (req_write)  state_d = ST_WRITE;
                    else if (hit)   cpu_ready = 1'b1;
                    else            state_d = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (mem_r_ready) begin
                    refill_we = 1'b1;
                    if (off_q == LAST_OFF) begin
                        tag_we  = 1'b1;
                        state_d = ST_LOOKUP;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_w_ready) begin
                    cpu_ready = 1'b1;
                    store_we  = hit;
                    state_d   = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // Refill word counter, advancing on each accepted memory read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   off_q <= '0;
        else if ((state_q == ST_REFILL) && mem_r_ready) off_q <= off_q + 1'b1;
    end

    always_comb begin
        mem_r_valid = (state_q == ST_REFILL);
        mem_w_valid = (state_q == ST_WRITE);
        refill_off  = off_q;
    end
endmodule

// File: rtl/dcache_frontend.sv
// Direct-mapped write-through cache between a processor word port and a memory port.
// A request register stages each accepted request; hits answer the next cycle,
// misses refill a full line, stores go to memory and stall until accepted.
// Assumes LINE_WORDS and LINES are powers of two, LINE_WORDS >= 2, DATA_W a multiple of 8.
module dcache_frontend #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 16,
    localparam int BYTES  = DATA_W / 8,
    localparam int BOFF_W = $clog2(BYTES),
    localparam int WOFF_W = $clog2(LINE_WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BYTES-1:0]  cpu_wstrb,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_r_valid,
    output logic [ADDR_W-1:0] mem_r_addr,
    input  logic [DATA_W-1:0] mem_r_data,
    input  logic              mem_r_ready,
    output logic              mem_w_valid,
    output logic [ADDR_W-1:0] mem_w_addr,
    output logic [DATA_W-1:0] mem_w_data,
    output logic [BYTES-1:0]  mem_w_strb,
    input  logic              mem_w_ready
);
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BYTES-1:0]  wstrb_q;
    logic              accept;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WOFF_W-1:0] req_off;
    logic              req_write;

    logic              hit;
    logic [WOFF_W-1:0] refill_off;
    logic              refill_we, tag_we, store_we;

    logic              dw_en;
    logic [WOFF_W-1:0] dw_off;
    logic [BYTES-1:0]  dw_be;
    logic [DATA_W-1:0] dw_data;

    // A new request is taken when the stage is empty or its occupant completes now.
    always_comb accept = cpu_valid && (!req_q || cpu_ready);

    // Request stage: capture on accept, empty when the last request completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            wstrb_q <= '0;
        end else if (accept) begin
            req_q   <= 1'b1;
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
            wstrb_q <= cpu_wstrb;
        end else if (cpu_ready) begin
            req_q   <= 1'b0;
        end
    end

    // Split the staged address into its fields.
    always_comb begin
        req_tag   = addr_q[ADDR_W-1 -: TAG_W];
        req_idx   = addr_q[BOFF_W+WOFF_W +: IDX_W];
        req_off   = addr_q[BOFF_W +: WOFF_W];
        req_write = |wstrb_q;
    end

    dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_tag (req_tag),
        .hit    (hit),
        .wr_en  (tag_we),
        .wr_idx (req_idx),
        .wr_tag (req_tag)
    );

    dc_ctrl #(.LINE_WORDS(LINE_WORDS)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_q),
        .req_write   (req_write),
        .hit         (hit),
        .mem_r_ready (mem_r_ready),
        .mem_w_ready (mem_w_ready),
        .cpu_ready   (cpu_ready),
        .mem_r_valid (mem_r_valid),
        .mem_w_valid (mem_w_valid),
        .refill_off  (refill_off),
        .refill_we   (refill_we),
        .tag_we      (tag_we),
        .store_we    (store_we)
    );

    // Data write source: refill words are whole, store hits use the byte enables.
    always_comb begin
        dw_en   = refill_we || store_we;
        dw_off  = refill_we ? refill_off : req_off;
        dw_be   = refill_we ? {BYTES{1'b1}} : wstrb_q;
        dw_data = refill_we ? mem_r_data : wdata_q;
    end

    dc_data_store #(.DATA_W(DATA_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)) data_i (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_off  (req_off),
        .rd_data (cpu_rdata),
        .wr_en   (dw_en),
        .wr_idx  (req_idx),
        .wr_off  (dw_off),
        .wr_be   (dw_be),
        .wr_data (dw_data)
    );

    // Memory-side addresses and store payload, all from the staged request.
    always_comb begin
        mem_r_addr = {req_tag, req_idx, refill_off, {BOFF_W{1'b0}}};
        mem_w_addr = {addr_q[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
        mem_w_data = wdata_q;
        mem_w_strb = wstrb_q;
    end
endmodule

// File: rtl/dc_checker.sv
// Protocol checker for the cache front end, bound to every instance of the top.
// Keeps its own model of whether a processor request is outstanding.
module dc_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int BOFF_W = $clog2(BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              mem_r_valid,
    input logic [ADDR_W-1:0] mem_r_addr,
    input logic              mem_r_ready,
    input logic              mem_w_valid,
    input logic [ADDR_W-1:0] mem_w_addr,
    input logic [DATA_W-1:0] mem_w_data,
    input logic [BYTES-1:0]  mem_w_strb,
    input logic              mem_w_ready
);
    logic pend_q;

    // Track whether the processor has a request waiting for ready.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pend_q <= 1'b0;
        else if (cpu_valid && (!pend_q || cpu_ready)) pend_q <= 1'b1;
        else if (cpu_ready)                      pend_q <= 1'b0;
    end

    assert_ready_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> pend_q);

    assert_idle_memory_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |-> (!mem_r_valid && !mem_w_valid));

    assert_refill_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_r_valid |-> (mem_r_addr[BOFF_W-1:0] == '0));

    assert_store_has_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_w_valid |-> (mem_w_strb != '0));

    assert_store_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_w_valid && mem_w_ready) |-> cpu_ready);

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_r_valid && !mem_r_ready) |=> (mem_r_valid && $stable(mem_r_addr)));

    assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_w_valid && !mem_w_ready) |=>
            (mem_w_valid && $stable(mem_w_addr) && $stable(mem_w_data) && $stable(mem_w_strb)));

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_r_valid && mem_w_valid));
endmodule

bind dcache_frontend dc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_valid   (cpu_valid),
    .cpu_ready   (cpu_ready),
    .mem_r_valid (mem_r_valid),
    .mem_r_addr  (mem_r_addr),
    .mem_r_ready (mem_r_ready),
    .mem_w_valid (mem_w_valid),
    .mem_w_addr  (mem_w_addr),
    .mem_w_data  (mem_w_data),
    .mem_w_strb  (mem_w_strb),
    .mem_w_ready (mem_w_ready)
);

// File: tb/dcache_frontend_tb_top.sv
module dcache_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_wstrb = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_r_valid, mem_w_valid;
    logic [31:0] mem_r_addr, mem_w_addr, mem_w_data;
    logic [3:0]  mem_w_strb;
    logic [31:0] mem_r_data = '0;
    logic        mem_r_ready = 1'b0;
    logic        mem_w_ready = 1'b0;

    always #5 clk = ~clk;

    dcache_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_r_valid(mem_r_valid), .mem_r_addr(mem_r_addr),
        .mem_r_data(mem_r_data), .mem_r_ready(mem_r_ready), .mem_w_valid(mem_w_valid),
        .mem_w_addr(mem_w_addr), .mem_w_data(mem_w_data), .mem_w_strb(mem_w_strb),
        .mem_w_ready(mem_w_ready)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // External memory model and the bench's own expected memory image.
    logic [31:0] shadow [256];
    logic [31:0] gold   [256];
    int          mem_lat = 0;
    int          wait_cnt = 0;
    int          rd_total = 0;
    logic [31:0] rd_log [4];
    int          wr_total = 0;
    logic [31:0] wr_addr_log, wr_data_log;
    logic [3:0]  wr_strb_log;

    // Bench model of which lines the cache should hold.
    logic        mv [16];
    logic [23:0] mt [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder: answers after mem_lat waiting cycles, one transfer per answer.
    always @(negedge clk) begin
        if (mem_r_ready || mem_w_ready) wait_cnt = 0;
        mem_r_ready = 1'b0;
        mem_w_ready = 1'b0;
        if (mem_r_valid) begin
            if (wait_cnt >= mem_lat) begin
                mem_r_ready = 1'b1;
                mem_r_data  = shadow[mem_r_addr[9:2]];
                rd_log[rd_total % 4] = mem_r_addr;
                rd_total++;
            end else wait_cnt++;
        end else if (mem_w_valid) begin
            if (wait_cnt >= mem_lat) begin
                mem_w_ready = 1'b1;
                for (int b = 0; b < 4; b++)
                    if (mem_w_strb[b]) shadow[mem_w_addr[9:2]][b*8 +: 8] = mem_w_data[b*8 +: 8];
                wr_addr_log = mem_w_addr;
                wr_data_log = mem_w_data;
                wr_strb_log = mem_w_strb;
                wr_total++;
            end else wait_cnt++;
        end else wait_cnt = 0;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    // One isolated access: returns read data and the cycle count until ready.
    task automatic access(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                          output logic [31:0] rd, output int n);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_wstrb = s;
        n = 0;
        do begin
            @(negedge clk); #1;
            n++;
        end while (!cpu_ready && n < 60);
        rd = cpu_rdata;
        cpu_valid = 1'b0; cpu_wstrb = '0;
    endtask

    // Access checked against the bench's line model and memory image.
    task automatic model_access(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] rd;
        int n, exp_n, wr0, rd0;
        bit is_hit;
        is_hit = mv[a[7:4]] && (mt[a[7:4]] == a[31:8]);
        wr0 = wr_total; rd0 = rd_total;
        access(a, d, s, rd, n);
        if (s == 4'b0) begin
            exp_n = is_hit ? 1 : 6;
            chk(n == exp_n, is_hit ? "R2" : "R5", "load latency", n, exp_n);
            chk(rd == gold[a[9:2]], "R2", "load data", rd, gold[a[9:2]]);
            chk(wr_total == wr0, "R1", "load made no memory write", wr_total, wr0);
            chk(rd_total - rd0 == (is_hit ? 0 : 4), "R5", "refill word count",
                rd_total - rd0, is_hit ? 0 : 4);
            if (!is_hit) begin
                for (int k = 0; k < 4; k++)
                    chk(rd_log[k] == {a[31:4], 4'(k*4)}, "R5", "refill order", rd_log[k],
                        {a[31:4], 4'(k*4)});
                mv[a[7:4]] = 1'b1; mt[a[7:4]] = a[31:8];
            end
        end else begin
            gold[a[9:2]] = merge(gold[a[9:2]], d, s);
            chk(n == 2, "R6", "store latency", n, 2);
            chk(wr_total == wr0 + 1, "R6", "store forwarded once", wr_total, wr0 + 1);
            chk(wr_addr_log == {a[31:2], 2'b00}, "R6", "store address", wr_addr_log, {a[31:2], 2'b00});
            chk(wr_data_log == d, "R6", "store data", wr_data_log, d);
            chk(wr_strb_log == s, "R1", "store enables", {28'h0, wr_strb_log}, {28'h0, s});
            chk(rd_total == rd0, "R7", "store did not refill", rd_total, rd0);
        end
    endtask

    // Vectors: address, store data, byte enables (zero = load).
    localparam logic [67:0] VEC [10] = '{
        {32'h0000_0010, 32'h0,          4'h0},  // load miss, line 1 tag 0
        {32'h0000_0014, 32'h0,          4'h0},  // load hit
        {32'h0000_0018, 32'hDEAD_BEEF, 4'hF},  // store hit, full word
        {32'h0000_0018, 32'h0,          4'h0},  // load hit of stored word
        {32'h0000_0118, 32'h1234_5678, 4'h3},  // store miss, no allocate (R7)
        {32'h0000_0118, 32'h0,          4'h0},  // load miss, replaces line 1
        {32'h0000_0018, 32'h0,          4'h0},  // load miss, word comes from memory
        {32'h0000_001C, 32'h00AA_0000, 4'h4},  // store hit, one byte (R7)
        {32'h0000_001C, 32'h0,          4'h0},  // load hit, merged byte
        {32'h0000_0040, 32'h0,          4'h0}   // load miss, another line
    };

    initial begin
        for (int i = 0; i < 256; i++) begin
            shadow[i] = 32'h1000_0000 + i * 32'h0101;
            gold[i]   = shadow[i];
        end
        for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; mt[i] = '0; end

        repeat (3) @(negedge clk);
        #1;
        chk(cpu_ready == 1'b0, "R8", "ready in reset", {31'h0, cpu_ready}, 0);
        chk(!mem_r_valid && !mem_w_valid, "R8", "memory idle in reset",
            {30'h0, mem_r_valid, mem_w_valid}, 0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int v = 0; v < 10; v++)
            model_access(VEC[v][67:36], VEC[v][35:4], VEC[v][3:0]);

        // R3: held strobe over resident line 1 (tag 0), one word per clock.
        @(negedge clk);
        cpu_valid = 1'b1; cpu_wstrb = '0; cpu_addr = 32'h10;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk(cpu_ready == 1'b1, "R3", "stream ready", {31'h0, cpu_ready}, 1);
            chk(cpu_rdata == gold[4 + k], "R3", "stream data", cpu_rdata, gold[4 + k]);
            if (k < 3) cpu_addr = 32'h10 + 32'((k + 1) * 4);
            else       cpu_valid = 1'b0;
        end
        // R4: strobe dropped in the last ready cycle, nothing further happens.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(!cpu_ready && !mem_r_valid && !mem_w_valid, "R4", "quiet after drop",
                {29'h0, cpu_ready, mem_r_valid, mem_w_valid}, 0);
        end

        // R10: load of the same word issued in the store's ready cycle.
        begin
            logic [31:0] expv;
            int n;
            expv = merge(gold[5], 32'h0000_7700, 4'h2);
            gold[5] = expv;
            @(negedge clk);
            cpu_valid = 1'b1; cpu_addr = 32'h14; cpu_wdata = 32'h0000_7700; cpu_wstrb = 4'h2;
            n = 0;
            do begin @(negedge clk); #1; n++; end while (!cpu_ready && n < 60);
            cpu_wstrb = '0;
            @(negedge clk); #1;
            chk(cpu_ready == 1'b1, "R10", "load right after store ready", {31'h0, cpu_ready}, 1);
            chk(cpu_rdata == expv, "R10", "forwarded store bytes", cpu_rdata, expv);
            cpu_valid = 1'b0;
        end

        // R9: slow memory, refill and store still correct.
        mem_lat = 2;
        begin
            logic [31:0] rd;
            int n;
            access(32'h0000_0200, 32'h0, 4'h0, rd, n);
            chk(rd == gold[8'h80], "R9", "slow refill data", rd, gold[8'h80]);
            chk(n == 14, "R9", "slow refill latency", n, 14);
            mv[0] = 1'b1; mt[0] = 24'h2;
            gold[8'h81] = merge(gold[8'h81], 32'hCAFE_0000, 4'hC);
            access(32'h0000_0204, 32'hCAFE_0000, 4'hC, rd, n);
            chk(wr_data_log == 32'hCAFE_0000 && wr_strb_log == 4'hC, "R9", "slow store payload",
                wr_data_log, 32'hCAFE_0000);
            chk(n == 4, "R9", "slow store latency", n, 4);
        end
        mem_lat = 0;
        model_access(32'h0000_0204, 32'h0, 4'h0);

        // R8: reset in the middle of the run invalidates every line.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mv[i] = 1'b0;
        begin
            logic [31:0] rd;
            int n;
            access(32'h0000_0014, 32'h0, 4'h0, rd, n);
            chk(n == 6, "R8", "first load after reset misses", n, 6);
            chk(rd == gold[5], "R8", "data after reset", rd, gold[5]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule